// File: doc/BRIEF.md
# Return-Address Shadow Stack Checker

This block keeps a private on-chip copy of return addresses next to a processor's ordinary call and return flow. Every call event stores the return address on the shadow stack. Every return event takes the top shadow entry and compares it with the address the core fetched from the ordinary stack. A difference, or a return with nothing stacked, raises a protection fault. A call that finds the shadow stack full raises an overflow fault instead.

The pointer, which is the number of valid entries, can be read at any time and loaded by software. This lets non-local jump save and restore code bring it back into step. Entries are not cleared by a load, so restoring an earlier pointer value exposes the entries that were stacked below it. On a call the pointer advances in the event cycle, and the slot is written one cycle later through a staging register. A return in the very next cycle is served from that staging register.

Top module: `shadow_stack_guard`

## Requirements
- R1: A call event alone (call_i high, ret_i low, ptr_we_i low) on a stack that is not full stores call_addr_i and makes ptr_o one higher after the clock edge, with no fault.
- R2: A return event alone whose ret_addr_i equals the top entry makes ptr_o one lower after the edge, with no fault.
- R3: A return event alone whose ret_addr_i differs from the top entry pulses cp_fault_o and leaves ptr_o unchanged.
- R4: A return event alone while ptr_o is 0 pulses cp_fault_o and ptr_o stays 0.
- R5: A call event alone while ptr_o equals DEPTH pulses ovf_fault_o and changes neither ptr_o nor any stored entry, so later returns still match the earlier calls.
- R6: cp_fault_o, ovf_fault_o and illegal_o are high only in the cycle after the event that causes them, and at most one of them is high in any cycle.
- R7: call_i and ret_i high together without ptr_we_i pulses illegal_o and changes neither ptr_o nor the contents.
- R8: ptr_we_i loads ptr_wdata_i into the pointer, clamped to DEPTH. It takes precedence, so call_i and ret_i in the same cycle are ignored and raise no output pulse. The stored entries are kept.
- R9: After reset ptr_o is 0 and all three pulse outputs are low.
- R10: A return in the cycle right after a call is compared with the address of that call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call event strobe |
| call_addr_i | input | AW | Return address pushed by the call |
| ret_i | input | 1 | Return event strobe |
| ret_addr_i | input | AW | Return address read from the ordinary stack |
| ptr_we_i | input | 1 | Pointer load strobe |
| ptr_wdata_i | input | PW | Pointer value to load |
| ptr_o | output | PW | Current pointer (entry count) |
| cp_fault_o | output | 1 | Mismatch or empty-return fault pulse |
| ovf_fault_o | output | 1 | Overflow fault pulse |
| illegal_o | output | 1 | Simultaneous call and return pulse |

## Verification
The hardest state to reach from the ports is a return that arrives while the matching entry is still held in the staging register and not yet written into the array. Reaching it takes a call immediately followed by a return. Directed back-to-back call and return pairs cover this case, and the random mix produces such pairs often. A second hard case is a restored pointer that points at entries pushed before a later overflow or rewind. The stimulus saves ptr_o, runs random traffic, then reloads the saved value and keeps returning against the model's copy of the entries.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [2:0] {
    EV_IDLE,
    EV_LOAD,
    EV_PUSH,
    EV_POP,
    EV_CLASH
  } ss_ev_e;
endpackage

// File: rtl/ss_store.sv
module ss_store #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o
);
  logic [AW-1:0] mem_q [DEPTH];
  logic          stg_vld_q;
  logic [IW-1:0] stg_idx_q;
  logic [AW-1:0] stg_data_q;

  // slot is written the cycle after the pointer has moved
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_vld_q  <= 1'b0;
      stg_idx_q  <= '0;
      stg_data_q <= '0;
    end else begin
      stg_vld_q <= wr_en_i;
      if (wr_en_i) begin
        stg_idx_q  <= wr_idx_i;
        stg_data_q <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (stg_vld_q) mem_q[stg_idx_q] <= stg_data_q;
  end

  assign rd_data_o = (stg_vld_q && stg_idx_q == rd_idx_i) ? stg_data_q : mem_q[rd_idx_i];

  AST_STAGE_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stg_vld_q && !wr_en_i) |=> !stg_vld_q); // R10
endmodule

// File: rtl/ss_ctrl.sv
module ss_ctrl
  import ss_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [AW-1:0] ret_addr_i,
  input  logic          ptr_we_i,
  input  logic [PW-1:0] ptr_wdata_i,
  input  logic [AW-1:0] top_data_i,
  output logic [PW-1:0] ptr_o,
  output logic          push_o,
  output logic          cp_fault_o,
  output logic          ovf_fault_o,
  output logic          illegal_o
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  ss_ev_e        ev;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          cp_d, ovf_d, ill_d;
  logic          empty, full;

  assign empty = (ptr_q == '0);
  assign full  = (ptr_q == FULL);

  always_comb begin
    if (ptr_we_i)             ev = EV_LOAD;
    else if (call_i && ret_i) ev = EV_CLASH;
    else if (call_i)          ev = EV_PUSH;
    else if (ret_i)           ev = EV_POP;
    else                      ev = EV_IDLE;
  end

  always_comb begin
    ptr_d  = ptr_q;
    cp_d   = 1'b0;
    ovf_d  = 1'b0;
    ill_d  = 1'b0;
    push_o = 1'b0;
    unique case (ev)
      EV_LOAD:  ptr_d = (ptr_wdata_i > FULL) ? FULL : ptr_wdata_i;
      EV_CLASH: ill_d = 1'b1;
      EV_PUSH: begin
        if (full) ovf_d = 1'b1;
        else begin
          push_o = 1'b1;
          ptr_d  = ptr_q + 1'b1;
        end
      end
      EV_POP: begin
        if (empty || top_data_i != ret_addr_i) cp_d = 1'b1;
        else ptr_d = ptr_q - 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      cp_fault_o  <= 1'b0;
      ovf_fault_o <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      ptr_q       <= ptr_d;
      cp_fault_o  <= cp_d;
      ovf_fault_o <= ovf_d;
      illegal_o   <= ill_d;
    end
  end

  assign ptr_o = ptr_q;

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= FULL); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cp_fault_o, ovf_fault_o, illegal_o}) <= 1); // R6
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && !ptr_we_i && ptr_q == '0) |=> (cp_fault_o && ptr_q == '0)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && !ptr_we_i && ptr_q == FULL) |=> (ovf_fault_o && ptr_q == FULL)); // R5
  AST_CLASH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && ret_i && !ptr_we_i) |=> (illegal_o && $stable(ptr_q))); // R7
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_fault_o |-> ptr_q == $past(ptr_q)); // R3
endmodule

// File: rtl/shadow_stack_guard.sv
module shadow_stack_guard #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic [AW-1:0] call_addr_i,
  input  logic          ret_i,
  input  logic [AW-1:0] ret_addr_i,
  input  logic          ptr_we_i,
  input  logic [PW-1:0] ptr_wdata_i,
  output logic [PW-1:0] ptr_o,
  output logic          cp_fault_o,
  output logic          ovf_fault_o,
  output logic          illegal_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          push;
  logic [AW-1:0] top_data;
  logic [PW-1:0] ptr_dec;

  assign ptr_dec = ptr_o - 1'b1;

  ss_ctrl #(.AW(AW), .DEPTH(DEPTH), .PW(PW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .ret_addr_i  (ret_addr_i),
    .ptr_we_i    (ptr_we_i),
    .ptr_wdata_i (ptr_wdata_i),
    .top_data_i  (top_data),
    .ptr_o       (ptr_o),
    .push_o      (push),
    .cp_fault_o  (cp_fault_o),
    .ovf_fault_o (ovf_fault_o),
    .illegal_o   (illegal_o)
  );

  ss_store #(.AW(AW), .DEPTH(DEPTH), .IW(IW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (push),
    .wr_idx_i  (ptr_o[IW-1:0]),
    .wr_data_i (call_addr_i),
    .rd_idx_i  (ptr_dec[IW-1:0]),
    .rd_data_o (top_data)
  );
endmodule

// File: tb/shadow_stack_guard_bench.sv
module shadow_stack_guard_bench;
  localparam int AW = 32;
  localparam int D  = 8;
  localparam int PW = $clog2(D + 1);

  logic          clk = 0, rst_n = 0;
  logic          call = 0, ret = 0, we = 0;
  logic [AW-1:0] call_addr = '0, ret_addr = '0;
  logic [PW-1:0] wdata = '0;
  logic [PW-1:0] ptr;
  logic          cpf, ovf, ill;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [AW-1:0] m_mem [D];
  int m_ptr = 0;
  logic e_cp = 0, e_ovf = 0, e_ill = 0;

  always #5 clk = ~clk;

  shadow_stack_guard #(.AW(AW), .DEPTH(D), .PW(PW)) u_shadow_stack_guard (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .call_addr_i(call_addr),
    .ret_i(ret), .ret_addr_i(ret_addr), .ptr_we_i(we), .ptr_wdata_i(wdata),
    .ptr_o(ptr), .cp_fault_o(cpf), .ovf_fault_o(ovf), .illegal_o(ill));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [AW-1:0] top_val();
    return (m_ptr > 0) ? m_mem[m_ptr-1] : '0;
  endfunction

  // model of one cycle, derived from R1..R8
  function automatic void model(logic c, logic [AW-1:0] ca, logic r, logic [AW-1:0] ra,
                                logic w, logic [PW-1:0] wd);
    e_cp = 0; e_ovf = 0; e_ill = 0;
    if (w) m_ptr = (int'(wd) > D) ? D : int'(wd);
    else if (c && r) e_ill = 1;
    else if (c) begin
      if (m_ptr == D) e_ovf = 1;
      else begin m_mem[m_ptr] = ca; m_ptr++; end
    end else if (r) begin
      if (m_ptr == 0 || m_mem[m_ptr-1] != ra) e_cp = 1;
      else m_ptr--;
    end
  endfunction

  task automatic step(string req, logic c, logic [AW-1:0] ca, logic r, logic [AW-1:0] ra,
                      logic w, logic [PW-1:0] wd);
    @(negedge clk);
    call = c; call_addr = ca; ret = r; ret_addr = ra; we = w; wdata = wd;
    model(c, ca, r, ra, w, wd);
    @(posedge clk); #1;
    chk({req, " ptr"}, 32'(ptr), 32'(m_ptr));
    chk({req, " cp_fault"}, 32'(cpf), 32'(e_cp));
    chk({req, " ovf_fault"}, 32'(ovf), 32'(e_ovf));
    chk({req, " illegal"}, 32'(ill), 32'(e_ill));
  endtask

  task automatic idle(string req);
    step(req, 0, '0, 0, '0, 0, '0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] saved;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R9 ptr", 32'(ptr), 0);
    chk("R9 cp", 32'(cpf), 0);
    chk("R9 ovf", 32'(ovf), 0);
    chk("R9 ill", 32'(ill), 0);
    @(negedge clk); rst_n = 1;

    step("R4 empty pop", 0, '0, 1, 32'h1234, 0, '0);
    idle("R6 pulse drop");
    for (int i = 0; i < D; i++) step("R1 push", 1, 32'h1000 + 32'(i*4), 0, '0, 0, '0);
    step("R5 overflow", 1, 32'hdead_beef, 0, '0, 0, '0);
    idle("R6 ovf drop");
    step("R3 mismatch", 0, '0, 1, 32'hbad0, 0, '0);
    for (int i = D-1; i >= 0; i--) step("R2 R5 pop", 0, '0, 1, 32'h1000 + 32'(i*4), 0, '0);
    step("R10 push", 1, 32'h7777, 0, '0, 0, '0);
    step("R10 pop next", 0, '0, 1, 32'h7777, 0, '0);
    step("R10 push", 1, 32'h8888, 0, '0, 0, '0);
    step("R10 bad next", 0, '0, 1, 32'h8889, 0, '0);
    step("R7 clash", 1, 32'h9999, 1, 32'h8888, 0, '0);
    step("R2 after clash", 0, '0, 1, 32'h8888, 0, '0);
    step("R8 clamp", 1, 32'h1, 1, '0, 1, PW'(15));
    step("R8 load", 0, '0, 0, '0, 1, PW'(3));
    step("R8 entries kept", 0, '0, 1, 32'h1008, 0, '0);

    saved = ptr;
    for (int k = 0; k < 4000; k++) begin
      int sel = int'($urandom_range(0, 99));
      if (k % 500 == 250) step("R8 restore", 0, '0, 0, '0, 1, saved);
      else if (k % 500 == 0) begin saved = ptr; idle("R8 save"); end
      else if (sel < 40) step("R1 rnd call", 1, $urandom, 0, '0, 0, '0);
      else if (sel < 75) step("R2 rnd ret", 0, '0, 1, top_val(), 0, '0);
      else if (sel < 85) step("R3 rnd bad", 0, '0, 1, top_val() ^ 32'h4, 0, '0);
      else if (sel < 90) step("R7 rnd clash", 1, $urandom, 1, top_val(), 0, '0);
      else if (sel < 93) step("R8 rnd load", $urandom_range(0,1) == 1, $urandom, 0, '0, 1,
                              PW'($urandom_range(0, 15)));
      else idle("R6 rnd idle");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule